// File: doc/BRIEF.md
# Conversion Start and Completion Controller for a Multi-Channel Converter

This block is the digital sequencing logic around a multi-channel successive-approximation converter. Software programs a small control word that holds a scan-mode bit, a 3-bit start selector, an inversion bit and a channel number. A conversion then begins in one of two ways. It begins at once when the written selector asks for an immediate start. It also begins on a qualified edge from one of six hardware trigger sources: two external capture/match pins and four timer match signals. The analog converter is not modelled. A fixed-length cycle counter stands in for it. When the count ends, the sample presented for the chosen channel is latched into the result register.

A finished conversion raises a completion flag. The interrupt request and the burst-type DMA request both follow that flag, and nothing else clears it except a read of the result. A conversion in progress cannot be aborted. Any start command or trigger edge that arrives during a conversion is discarded and is not remembered.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, `done`, `irq`, `dma_breq` and `conv_busy` are 0, and `result_data` and `result_chan` are 0.
- R2: A cycle with `ctrl_wr`=1, `ctrl_burst`=0 and `ctrl_code`=3'b001 starts a conversion on channel `ctrl_chan` at that clock edge, provided no conversion is running. `conv_busy` is 1 after that edge. `done` rises exactly CONV_CYCLES edges later, and `result_data` then holds that channel's slice `samples[ch*SAMPLE_W +: SAMPLE_W]` as it was at that final edge.
- R3: The stored start code picks the hardware source. 3'b010 selects `ext_trig[0]`, 3'b011 selects `ext_trig[1]`, and 3'b100 to 3'b111 select `match_trig[0]` to `match_trig[3]`. Activity on a source that is not selected starts nothing.
- R4: The selected source is XORed with the stored inversion bit (`ctrl_fall`). That value passes through two synchronizer flops, and only its 0-to-1 transition starts a conversion. `conv_busy` rises on the third rising clock edge after the source changes. A 1-to-0 transition of the XOR value starts nothing.
- R5: While the stored scan-mode bit is 1, or the stored code is 3'b000, no hardware edge starts a conversion. A control write with `ctrl_burst`=1 never starts one.
- R6: A software start or a trigger edge that arrives while `conv_busy` is 1 is dropped and is not queued. The running conversion keeps its channel.
- R7: A running conversion always lasts the full CONV_CYCLES edges, even if the control word is rewritten during it.
- R8: `irq` and `dma_breq` equal `done` in every cycle.
- R9: A cycle with `rd_result`=1 clears `done` at that edge. If a conversion finishes at the same edge, `done` stays 1 and the new result is kept.
- R10: `result_chan` reports the channel of the conversion that produced `result_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_burst | input | 1 | Scan-mode bit; 1 blocks every start |
| ctrl_code | input | 3 | Start selector |
| ctrl_fall | input | 1 | Trigger inversion bit (1 = falling edge) |
| ctrl_chan | input | CHW | Channel to convert |
| ext_trig | input | 2 | External capture/match pins |
| match_trig | input | 4 | Timer match signals |
| samples | input | NUM_CH*SAMPLE_W | Per-channel sample values from the converter model |
| rd_result | input | 1 | Result read strobe |
| result_data | output | SAMPLE_W | Latched conversion result |
| result_chan | output | CHW | Channel of the latched result |
| conv_busy | output | 1 | Conversion in progress |
| done | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| dma_breq | output | 1 | Burst DMA request |

## Verification
A software start is accepted at the write edge, so `conv_busy` is sampled one cycle later. `done` is due CONV_CYCLES edges after that. A hardware trigger needs two more edges for synchronization, so `busy` is due at the third edge after the source moves and `done` at edge CONV_CYCLES+3. The bench counts these edges exactly. At every checkpoint it tests one edge before the due edge and then the due edge itself, and it samples on falling clock edges. Negative checks (dropped starts, wrong-direction edges, unselected sources, blocked modes) wait longer than a whole conversion, then confirm that `conv_busy` and `done` never moved.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam int unsigned NUM_HW_SRC = 6;

  localparam logic [2:0] CODE_NONE = 3'b000;
  localparam logic [2:0] CODE_NOW  = 3'b001;

  // a stored code names a hardware source when its upper two bits are not both 0
  function automatic logic code_is_hw(input logic [2:0] code);
    return code[2] | code[1];
  endfunction

  // source vector layout: [1:0] external pins, [5:2] timer matches
  function automatic logic [2:0] code_src_index(input logic [2:0] code);
    logic [2:0] idx;
    if (code[2]) idx = {1'b0, code[1:0]} + 3'd2;
    else         idx = {2'b00, code[0]};
    return idx;
  endfunction

endpackage

// File: rtl/adc_trig_select.sv
module adc_trig_select
  import adc_trig_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_HW_SRC-1:0] hw_srcs,
  input  logic [2:0]            code,
  input  logic                  invert,
  input  logic                  enable,
  output logic                  hw_edge
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic                   sel_raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  assign sel_raw = hw_srcs[code_src_index(code)] ^ invert;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= sel_raw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];

  assign hw_edge = enable & sync_q[LAST] & ~prev_q;

  // R4: one rise yields a single-cycle edge, never two in a row
  a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    hw_edge |=> !hw_edge);

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_CYCLES = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic start_go,
  output logic conv_finish,
  output logic busy
);

  localparam int unsigned CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign start_go    = start_req & ~busy_q;
  assign conv_finish = busy_q & (cnt_q == '0);
  assign busy        = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_go) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R7: a running conversion stays busy until its count ends
  a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !conv_finish |=> busy_q);

  // R6: requests during a conversion do not reload the counter
  a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !conv_finish && start_req |=> cnt_q != LOAD || CW'(CONV_CYCLES - 1) == '0);

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned CHW      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_go,
  input  logic [CHW-1:0]               start_chan,
  input  logic                         conv_busy,
  input  logic                         conv_finish,
  input  logic [NUM_CH*SAMPLE_W-1:0]   samples,
  input  logic                         rd_result,
  output logic [SAMPLE_W-1:0]          result_data,
  output logic [CHW-1:0]               result_chan,
  output logic                         done
);

  logic [SAMPLE_W-1:0] smp [NUM_CH];
  logic [CHW-1:0]      conv_chan_q;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slice
      assign smp[g] = samples[g*SAMPLE_W +: SAMPLE_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        conv_chan_q <= '0;
    else if (start_go) conv_chan_q <= start_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_data <= '0;
      result_chan <= '0;
      done        <= 1'b0;
    end else if (conv_finish) begin
      result_data <= smp[conv_chan_q];
      result_chan <= conv_chan_q;
      done        <= 1'b1;
    end else if (rd_result) begin
      done <= 1'b0;
    end
  end

  // R2: the finishing edge raises the completion flag
  a_r2_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    conv_finish |=> done);

  // R9: a read without a coincident completion clears the flag
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_result && !conv_finish |=> !done);

  // R6: the running conversion keeps its channel
  a_r6_chan_kept: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy && !conv_finish |=> $stable(conv_chan_q));

  // R10: reported channel is the one that was converting
  a_r10_chan_reported: assert property (@(posedge clk) disable iff (!rst_n)
    conv_finish |=> result_chan == $past(conv_chan_q));

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned SAMPLE_W    = 12,
  parameter int unsigned CONV_CYCLES = 65,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CHW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctrl_wr,
  input  logic                       ctrl_burst,
  input  logic [2:0]                 ctrl_code,
  input  logic                       ctrl_fall,
  input  logic [CHW-1:0]             ctrl_chan,
  input  logic [1:0]                 ext_trig,
  input  logic [3:0]                 match_trig,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  input  logic                       rd_result,
  output logic [SAMPLE_W-1:0]        result_data,
  output logic [CHW-1:0]             result_chan,
  output logic                       conv_busy,
  output logic                       done,
  output logic                       irq,
  output logic                       dma_breq
);

  logic           burst_q;
  logic [2:0]     code_q;
  logic           fall_q;
  logic [CHW-1:0] chan_q;

  logic           sw_start;
  logic           hw_enable;
  logic           hw_edge;
  logic           start_req;
  logic           start_go;
  logic           conv_finish;
  logic [CHW-1:0] start_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      code_q  <= CODE_NONE;
      fall_q  <= 1'b0;
      chan_q  <= '0;
    end else if (ctrl_wr) begin
      burst_q <= ctrl_burst;
      code_q  <= ctrl_code;
      fall_q  <= ctrl_fall;
      chan_q  <= ctrl_chan;
    end
  end

  assign sw_start   = ctrl_wr & ~ctrl_burst & (ctrl_code == CODE_NOW);
  assign hw_enable  = ~burst_q & code_is_hw(code_q);
  assign start_req  = sw_start | hw_edge;
  assign start_chan = ctrl_wr ? ctrl_chan : chan_q;

  adc_trig_select #(.SYNC_STAGES(SYNC_STAGES)) u_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_srcs ({match_trig, ext_trig}),
    .code    (code_q),
    .invert  (fall_q),
    .enable  (hw_enable),
    .hw_edge (hw_edge)
  );

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .start_go    (start_go),
    .conv_finish (conv_finish),
    .busy        (conv_busy)
  );

  adc_result_reg #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CHW(CHW)) u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_go    (start_go),
    .start_chan  (start_chan),
    .conv_busy   (conv_busy),
    .conv_finish (conv_finish),
    .samples     (samples),
    .rd_result   (rd_result),
    .result_data (result_data),
    .result_chan (result_chan),
    .done        (done)
  );

  assign irq      = done;
  assign dma_breq = done;

  // R5: a hardware edge never starts a conversion in scan mode
  a_r5_burst_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    burst_q && !sw_start |=> !$rose(conv_busy));

  // R2: an accepted software start is busy on the next cycle
  a_r2_sw_starts: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start && !conv_busy |=> conv_busy);

  // R8: both request lines track the completion flag after each edge
  a_r8_requests: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == done) && (dma_breq == done));

endmodule

// File: tb/adc_trig_ctrl_bench.sv
module adc_trig_ctrl_bench;

  localparam int NCH   = 4;
  localparam int SW    = 8;
  localparam int CONV  = 8;
  localparam int CHWB  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctrl_wr = 1'b0, ctrl_burst = 1'b0, ctrl_fall = 1'b0;
  logic [2:0]        ctrl_code = 3'b000;
  logic [CHWB-1:0]   ctrl_chan = '0;
  logic [1:0]        ext_trig = 2'b00;
  logic [3:0]        match_trig = 4'b0000;
  logic [NCH*SW-1:0] samples = '0;
  logic              rd_result = 1'b0;
  logic [SW-1:0]     result_data;
  logic [CHWB-1:0]   result_chan;
  logic              conv_busy, done, irq, dma_breq;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  adc_trig_ctrl #(.NUM_CH(NCH), .SAMPLE_W(SW), .CONV_CYCLES(CONV)) u_adc_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_burst(ctrl_burst),
    .ctrl_code(ctrl_code), .ctrl_fall(ctrl_fall), .ctrl_chan(ctrl_chan),
    .ext_trig(ext_trig), .match_trig(match_trig), .samples(samples),
    .rd_result(rd_result), .result_data(result_data), .result_chan(result_chan),
    .conv_busy(conv_busy), .done(done), .irq(irq), .dma_breq(dma_breq));

  function automatic int exp_sample(input int base, input int ch);
    return (base * 11 + ch * 37 + 5) % 256;
  endfunction

  task automatic load_samples(input int base);
    for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = SW'(exp_sample(base, c));
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input bit b, input int code, input bit f, input int ch);
    ctrl_wr = 1'b1; ctrl_burst = b; ctrl_code = 3'(code); ctrl_fall = f; ctrl_chan = CHWB'(ch);
    step(1);
    ctrl_wr = 1'b0;
  endtask

  task automatic do_read();
    rd_result = 1'b1; step(1); rd_result = 1'b0;
  endtask

  task automatic set_all_src(input bit v);
    ext_trig = {2{v}}; match_trig = {4{v}};
  endtask

  // bench's own source numbering: code 2,3 -> pins, 4..7 -> matches
  task automatic set_one_src(input int code, input bit v);
    if (code < 4) ext_trig[code-2] = v;
    else          match_trig[code-4] = v;
  endtask

  task automatic chk_done(input string tag, input bit exp);
    chk({tag, " done"}, int'(done), int'(exp));
    chk({"R8 irq ", tag}, int'(irq), int'(exp));
    chk({"R8 dma ", tag}, int'(dma_breq), int'(exp));
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    step(3);
    // R1: reset state
    chk("R1 busy", int'(conv_busy), 0);
    chk_done("R1", 1'b0);
    chk("R1 result", int'(result_data), 0);
    chk("R1 chan", int'(result_chan), 0);
    rst_n = 1'b1;
    step(2);

    // R2: software start on channel 2
    load_samples(1);
    wr_ctrl(0, 1, 0, 2);
    chk("R2 busy after write", int'(conv_busy), 1);
    step(CONV - 1);
    chk_done("R2 early", 1'b0);
    step(1);
    chk_done("R2 due", 1'b1);
    chk("R2 result", int'(result_data), exp_sample(1, 2));
    chk("R10 chan", int'(result_chan), 2);
    do_read();
    chk_done("R9 read", 1'b0);

    // R6: second start during conversion dropped, channel kept
    load_samples(2);
    wr_ctrl(0, 1, 0, 1);
    step(2);
    wr_ctrl(0, 1, 0, 3);
    step(CONV - 4);
    chk_done("R6 early", 1'b0);
    step(1);
    chk_done("R6 due", 1'b1);
    chk("R6 chan kept", int'(result_chan), 1);
    chk("R6 result", int'(result_data), exp_sample(2, 1));
    do_read();
    step(CONV + 4);
    chk("R6 not queued busy", int'(conv_busy), 0);
    chk_done("R6 not queued", 1'b0);

    // R7: rewriting control mid-conversion does not abort
    load_samples(3);
    wr_ctrl(0, 1, 0, 0);
    wr_ctrl(1, 0, 0, 0);
    step(CONV - 2);
    chk("R7 still busy", int'(conv_busy), 1);
    step(1);
    chk_done("R7 completes", 1'b1);
    chk("R7 result", int'(result_data), exp_sample(3, 0));
    do_read();

    // R5: scan mode or idle code never starts
    wr_ctrl(1, 1, 0, 0);
    step(CONV + 4);
    chk("R5 burst sw busy", int'(conv_busy), 0);
    chk_done("R5 burst sw", 1'b0);
    wr_ctrl(0, 0, 0, 0);
    step(CONV + 4);
    chk("R5 idle code busy", int'(conv_busy), 0);
    set_all_src(1'b0);
    wr_ctrl(1, 4, 0, 0);
    step(4);
    match_trig[0] = 1'b1;
    step(CONV + 6);
    chk("R5 burst hw busy", int'(conv_busy), 0);
    chk_done("R5 burst hw", 1'b0);

    // R9: read at the completing edge keeps done and new data
    load_samples(4);
    wr_ctrl(0, 1, 0, 3);
    step(CONV + 2);
    chk_done("R9 prep", 1'b1);
    load_samples(5);
    wr_ctrl(0, 1, 0, 2);
    step(CONV - 1);
    rd_result = 1'b1;
    step(1);
    rd_result = 1'b0;
    chk_done("R9 collide", 1'b1);
    chk("R9 new data", int'(result_data), exp_sample(5, 2));
    do_read();
    chk_done("R9 cleared", 1'b0);

    // R3/R4: sweep every hardware code with both polarities
    for (int code = 2; code < 8; code++) begin
      for (int f = 0; f < 2; f++) begin
        wr_ctrl(0, 0, 0, 0);
        set_all_src(f[0]);
        step(4);
        wr_ctrl(0, code, f[0], code % NCH);
        step(4);
        load_samples(code * 2 + f);
        set_all_src(!f[0]);
        set_one_src(code, f[0]);
        step(CONV + 6);
        chk("R3 unselected busy", int'(conv_busy), 0);
        chk("R3 unselected done", int'(done), 0);
        set_all_src(f[0]);
        step(4);
        set_one_src(code, !f[0]);
        step(2);
        chk("R4 not yet busy", int'(conv_busy), 0);
        step(1);
        chk("R4 busy third edge", int'(conv_busy), 1);
        step(CONV - 1);
        chk("R3 early done", int'(done), 0);
        step(1);
        chk_done("R3 hw due", 1'b1);
        chk("R3 result", int'(result_data), exp_sample(code * 2 + f, code % NCH));
        chk("R10 hw chan", int'(result_chan), code % NCH);
        do_read();
        set_one_src(code, f[0]);
        step(CONV + 6);
        chk("R4 wrong edge busy", int'(conv_busy), 0);
        chk("R4 wrong edge done", int'(done), 0);
      end
    end

    summary();
  end

endmodule